// File: doc/BRIEF.md
# SECDED-Protected RAM with Per-Requester Error Records

This block wraps a single-port word memory with single-error-correct, double-error-detect coding and keeps one error record set for each requester tag (for example one per security state). Every write stores the data together with its check bits. Every read checks the stored codeword. A single flipped bit is repaired before the data leaves the block. Two flipped bits are reported to the requester with an error flag.

When detection is enabled for the tag of the failing read, the record set for that tag logs a status word and the word address, and raises a level interrupt. There is one interrupt line per tag for corrected faults and one for uncorrectable faults. Software reaches each record set through a small register port and can arm a one-shot fault injection. The armed fault is applied to the next read made with that same tag, which lets the handling path be tested without real RAM faults.

Each record set holds a three-state machine with the states REC_EMPTY, REC_CE and REC_UE. The transitions are:
- log_ce: REC_EMPTY to REC_CE, on a corrected fault while detection is on.
- log_ue: REC_EMPTY to REC_UE, on an uncorrectable fault while detection is on.
- overflow_hold: REC_CE or REC_UE stays in its state and sets the overflow flag, on any further fault while detection is on.
- sw_clear: REC_CE or REC_UE returns to REC_EMPTY, on a status write with bit 31 set. If a fault arrives in the same cycle as the clear, that fault is logged into the emptied record.

Top module: `secded_rec_ram`

## Requirements
- R1: A read request (`mem_req`=1, `mem_we`=0) returns `mem_rvalid`=1 with the stored word on `mem_rdata` exactly one cycle later, with `mem_rerr`=0 when the codeword is clean.
- R2: With inject field 01 (control bits 5:4), the next read by that tag has one data bit flipped. The read still returns the original data with `mem_rerr`=0. With detection on, the tag's status reads 0x86000000 (bit 31 address valid, bit 26 misc valid, bits 25:24 = 10) and its address register reads the word address.
- R3: With inject field 10, the next read by that tag has two data bits flipped and returns `mem_rerr`=1. With detection on, the status reads 0xA4000000 (bits 31, 29, 26) and the address register reads the word address.
- R4: Writing the inject field alone logs nothing. The field reads back as 00 after the next read by that tag. The read after that is clean and leaves the record unchanged.
- R5: A fault is logged only into the record set of the failing read's tag. A read by another tag neither uses nor clears an armed injection.
- R6: A fault detected while a record is held sets overflow bit 27. The first status code and address are kept (a held UE plus a new fault reads 0xAC000000).
- R7: A status write (register select 1) with bit 31 set, for example 0xFFC00000, returns the record to empty: status 0 and address 0. It also drops that tag's interrupts.
- R8: `irq_corr[t]` is high exactly while tag t holds a corrected record, control bit 2 is set and detection is on. `irq_fault[t]` is high exactly while tag t holds an uncorrectable record, control bit 1 is set and detection is on.
- R9: While control bit 0 (detection) is clear, no record is written and no interrupt is raised. Read data is still corrected, and `mem_rerr` is still flagged.
- R10: After reset, every control, status and address register reads 0, all interrupts are low and `mem_rvalid` is low.
- R11: A write access produces no `mem_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mem_req | input | 1 | Memory access request |
| mem_we | input | 1 | 1 = write, 0 = read |
| mem_tag | input | TAG_W | Requester tag of the access |
| mem_addr | input | ADDR_W | Word address |
| mem_wdata | input | DATA_W | Write data |
| mem_rvalid | output | 1 | Read data valid, one cycle after a read request |
| mem_rdata | output | DATA_W | Corrected read data |
| mem_rerr | output | 1 | Uncorrectable fault on this read |
| reg_wr | input | 1 | Register write strobe |
| reg_tag | input | TAG_W | Record set selected for register access |
| reg_sel | input | 2 | 0 control, 1 status, 2 address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq_fault | output | TAGS | Uncorrectable-fault interrupt per tag |
| irq_corr | output | TAGS | Corrected-fault interrupt per tag |

## Verification
The bench builds the block with its defaults: 32-bit data, 16 words and four tags. Sixteen words let the vector table reach both the first and the last address. With 32 data bits, each stored word carries six Hamming check bits and one overall parity bit. Four tags make it possible to arm one set while faulting another, and to check that every other set stays empty. The one-shot inject path gives deterministic single and double faults, so every record transition, the overflow hold and the clear-with-interrupt-drop path can be reached without corrupting the RAM array itself.

// File: rtl/secded_rec_pkg.sv
package secded_rec_pkg;

    // Control register fields
    localparam int CT_DET = 0;
    localparam int CT_UEI = 1;
    localparam int CT_CEI = 2;
    localparam int CT_INJ = 4;

    // Status register fields
    localparam int ST_AV  = 31;
    localparam int ST_UE  = 29;
    localparam int ST_OF  = 27;
    localparam int ST_MV  = 26;
    localparam int ST_CE  = 24;

    // Register selects
    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_STAT = 2'd1;
    localparam logic [1:0] SEL_ADDR = 2'd2;

    // Inject codes
    localparam logic [1:0] INJ_NONE = 2'b00;
    localparam logic [1:0] INJ_ONE  = 2'b01;
    localparam logic [1:0] INJ_TWO  = 2'b10;

    // Codeword positions holding data bits 0 and 1
    localparam int FLIP_A = 3;
    localparam int FLIP_B = 5;

    typedef enum logic [1:0] {
        REC_EMPTY = 2'd0,
        REC_CE    = 2'd1,
        REC_UE    = 2'd2
    } rec_state_e;

    function automatic int chk_bits(input int dw);
        int p;
        p = 0;
        while ((1 << p) < dw + p + 1) p++;
        return p;
    endfunction

endpackage

// File: rtl/secded_enc.sv
module secded_enc #(
    parameter int DATA_W = 32,
    parameter int P_W    = 6,
    parameter int CW_W   = DATA_W + P_W + 1
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [CW_W-1:0]   cw_o
);
    localparam int N = DATA_W + P_W;

    always_comb begin
        int  di;
        logic acc;
        cw_o = '0;
        di   = 0;
        for (int pos = 1; pos <= N; pos++) begin
            if ((pos & (pos - 1)) != 0) begin
                cw_o[pos] = data_i[di];
                di++;
            end
        end
        for (int p = 0; p < P_W; p++) begin
            acc = 1'b0;
            for (int pos = 1; pos <= N; pos++) begin
                if (((pos >> p) & 1) == 1 && pos != (1 << p)) acc ^= cw_o[pos];
            end
            cw_o[1 << p] = acc;
        end
        cw_o[0] = ^cw_o[N:1];
    end

endmodule

// File: rtl/secded_dec.sv
module secded_dec #(
    parameter int DATA_W = 32,
    parameter int P_W    = 6,
    parameter int CW_W   = DATA_W + P_W + 1
) (
    input  logic [CW_W-1:0]   cw_i,
    output logic [DATA_W-1:0] data_o,
    output logic              single_o,
    output logic              double_o
);
    localparam int N = DATA_W + P_W;

    logic [P_W-1:0]  syn;
    logic            par;
    logic [CW_W-1:0] fixed;

    always_comb begin
        int di;
        syn = '0;
        for (int pos = 1; pos <= N; pos++) begin
            if (cw_i[pos]) syn ^= P_W'(pos);
        end
        par      = ^cw_i;
        single_o = par && (int'(syn) <= N);
        double_o = (!par && syn != '0) || (par && int'(syn) > N);
        fixed    = cw_i;
        if (single_o && syn != '0) fixed[syn] = ~cw_i[syn];
        data_o = '0;
        di     = 0;
        for (int pos = 1; pos <= N; pos++) begin
            if ((pos & (pos - 1)) != 0) begin
                data_o[di] = fixed[pos];
                di++;
            end
        end
    end

endmodule

// File: rtl/secded_word_store.sv
module secded_word_store #(
    parameter int CW_W   = 39,
    parameter int ADDR_W = 4,
    parameter int DEPTH  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CW_W-1:0]   wdata,
    output logic [CW_W-1:0]   rdata
);
    logic [CW_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[addr] <= wdata;
        if (rd_en) rdata <= mem_q[addr];
    end

endmodule

// File: rtl/secded_err_record.sv
module secded_err_record
    import secded_rec_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic              wr_stat,
    input  logic [31:0]       wdata,
    input  logic              ev_ce,
    input  logic              ev_ue,
    input  logic [ADDR_W-1:0] ev_addr,
    input  logic              rd_consume,
    output logic [1:0]        inj_mode,
    output logic [31:0]       ctrl_rd,
    output logic [31:0]       stat_rd,
    output logic [31:0]       addr_rd,
    output logic              irq_fault,
    output logic              irq_corr
);
    rec_state_e        state_q, state_d, base;
    logic              ov_q, ov_d;
    logic [ADDR_W-1:0] addr_q, addr_d;
    logic              det_q, uei_q, cei_q;
    logic [1:0]        inj_q;
    logic              clr, ev_log;

    assign clr    = wr_stat && wdata[ST_AV];
    assign ev_log = det_q && (ev_ce || ev_ue);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= REC_EMPTY;
            ov_q    <= 1'b0;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            ov_q    <= ov_d;
            addr_q  <= addr_d;
        end
    end

    // Control register with self-clearing inject field
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            det_q <= 1'b0;
            uei_q <= 1'b0;
            cei_q <= 1'b0;
            inj_q <= INJ_NONE;
        end else begin
            if (wr_ctrl) begin
                det_q <= wdata[CT_DET];
                uei_q <= wdata[CT_UEI];
                cei_q <= wdata[CT_CEI];
                inj_q <= wdata[CT_INJ +: 2];
            end
            if (rd_consume) inj_q <= INJ_NONE;
        end
    end

    // Next state
    always_comb begin
        base    = clr ? REC_EMPTY : state_q;
        state_d = base;
        ov_d    = clr ? 1'b0 : ov_q;
        addr_d  = clr ? '0 : addr_q;
        unique case (base)
            REC_EMPTY: begin
                if (ev_log) begin
                    state_d = ev_ue ? REC_UE : REC_CE;
                    addr_d  = ev_addr;
                end
            end
            REC_CE, REC_UE: begin
                if (ev_log) ov_d = 1'b1;
            end
            default: state_d = REC_EMPTY;
        endcase
    end

    // Outputs
    always_comb begin
        stat_rd   = '0;
        irq_fault = 1'b0;
        irq_corr  = 1'b0;
        unique case (state_q)
            REC_EMPTY: ;
            REC_CE: begin
                stat_rd[ST_AV]        = 1'b1;
                stat_rd[ST_MV]        = 1'b1;
                stat_rd[ST_CE +: 2]   = 2'b10;
                irq_corr              = det_q && cei_q;
            end
            REC_UE: begin
                stat_rd[ST_AV] = 1'b1;
                stat_rd[ST_MV] = 1'b1;
                stat_rd[ST_UE] = 1'b1;
                irq_fault      = det_q && uei_q;
            end
            default: ;
        endcase
        stat_rd[ST_OF] = ov_q;
        ctrl_rd        = '0;
        ctrl_rd[CT_DET]      = det_q;
        ctrl_rd[CT_UEI]      = uei_q;
        ctrl_rd[CT_CEI]      = cei_q;
        ctrl_rd[CT_INJ +: 2] = inj_q;
        addr_rd              = 32'(addr_q);
        inj_mode             = inj_q;
    end

endmodule

// File: rtl/secded_rec_ram.sv
module secded_rec_ram
    import secded_rec_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4,
    parameter int TAGS   = 4,
    parameter int TAG_W  = $clog2(TAGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mem_req,
    input  logic              mem_we,
    input  logic [TAG_W-1:0]  mem_tag,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_wdata,
    output logic              mem_rvalid,
    output logic [DATA_W-1:0] mem_rdata,
    output logic              mem_rerr,
    input  logic              reg_wr,
    input  logic [TAG_W-1:0]  reg_tag,
    input  logic [1:0]        reg_sel,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic [TAGS-1:0]   irq_fault,
    output logic [TAGS-1:0]   irq_corr
);
    localparam int P_W   = chk_bits(DATA_W);
    localparam int CW_W  = DATA_W + P_W + 1;
    localparam int DEPTH = 1 << ADDR_W;

    logic              rd_go, wr_go;
    logic [CW_W-1:0]   wr_cw, rd_cw, rd_cw_inj;
    logic              rd_pend_q;
    logic [TAG_W-1:0]  rd_tag_q;
    logic [ADDR_W-1:0] rd_addr_q;
    logic [1:0]        rd_inj_q;
    logic              dec_single, dec_double;

    logic [1:0]  inj_arr  [TAGS];
    logic [31:0] ctrl_arr [TAGS];
    logic [31:0] stat_arr [TAGS];
    logic [31:0] addr_arr [TAGS];

    assign rd_go = mem_req && !mem_we;
    assign wr_go = mem_req && mem_we;

    secded_enc #(.DATA_W(DATA_W), .P_W(P_W), .CW_W(CW_W)) u_enc (
        .data_i (mem_wdata),
        .cw_o   (wr_cw)
    );

    secded_word_store #(.CW_W(CW_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .wr_en (wr_go),
        .rd_en (rd_go),
        .addr  (mem_addr),
        .wdata (wr_cw),
        .rdata (rd_cw)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_pend_q <= 1'b0;
            rd_tag_q  <= '0;
            rd_addr_q <= '0;
            rd_inj_q  <= INJ_NONE;
        end else begin
            rd_pend_q <= rd_go;
            if (rd_go) begin
                rd_tag_q  <= mem_tag;
                rd_addr_q <= mem_addr;
                rd_inj_q  <= inj_arr[mem_tag];
            end
        end
    end

    always_comb begin
        rd_cw_inj = rd_cw;
        if (rd_inj_q == INJ_ONE) begin
            rd_cw_inj[FLIP_A] = ~rd_cw[FLIP_A];
        end else if (rd_inj_q == INJ_TWO) begin
            rd_cw_inj[FLIP_A] = ~rd_cw[FLIP_A];
            rd_cw_inj[FLIP_B] = ~rd_cw[FLIP_B];
        end
    end

    secded_dec #(.DATA_W(DATA_W), .P_W(P_W), .CW_W(CW_W)) u_dec (
        .cw_i     (rd_cw_inj),
        .data_o   (mem_rdata),
        .single_o (dec_single),
        .double_o (dec_double)
    );

    assign mem_rvalid = rd_pend_q;
    assign mem_rerr   = rd_pend_q && dec_double;

    for (genvar t = 0; t < TAGS; t++) begin : g_rec
        logic hit_rd, hit_reg;
        assign hit_rd  = rd_pend_q && (rd_tag_q == TAG_W'(t));
        assign hit_reg = reg_wr && (reg_tag == TAG_W'(t));

        secded_err_record #(.ADDR_W(ADDR_W)) u_rec (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_ctrl    (hit_reg && reg_sel == SEL_CTRL),
            .wr_stat    (hit_reg && reg_sel == SEL_STAT),
            .wdata      (reg_wdata),
            .ev_ce      (hit_rd && dec_single),
            .ev_ue      (hit_rd && dec_double),
            .ev_addr    (rd_addr_q),
            .rd_consume (rd_go && (mem_tag == TAG_W'(t))),
            .inj_mode   (inj_arr[t]),
            .ctrl_rd    (ctrl_arr[t]),
            .stat_rd    (stat_arr[t]),
            .addr_rd    (addr_arr[t]),
            .irq_fault  (irq_fault[t]),
            .irq_corr   (irq_corr[t])
        );
    end

    always_comb begin
        unique case (reg_sel)
            SEL_CTRL: reg_rdata = ctrl_arr[reg_tag];
            SEL_STAT: reg_rdata = stat_arr[reg_tag];
            SEL_ADDR: reg_rdata = addr_arr[reg_tag];
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/secded_rec_ram_chk.sv
module secded_rec_ram_chk #(
    parameter int TAGS  = 4,
    parameter int TAG_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mem_req,
    input logic             mem_we,
    input logic             mem_rvalid,
    input logic             mem_rerr,
    input logic             reg_wr,
    input logic [TAG_W-1:0] reg_tag,
    input logic [1:0]       reg_sel,
    input logic [31:0]      reg_wdata,
    input logic [TAGS-1:0]  irq_fault,
    input logic [TAGS-1:0]  irq_corr
);
    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |=> mem_rvalid); // R1
    AST_NO_WRITE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rvalid |-> $past(mem_req && !mem_we)); // R11
    AST_RERR_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rerr |-> mem_rvalid); // R3

    for (genvar i = 0; i < TAGS; i++) begin : g_tag
        AST_IRQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
            !(irq_fault[i] && irq_corr[i])); // R8
        AST_FAULT_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq_fault[i]) |-> ($past(mem_rvalid && mem_rerr) || $past(reg_wr))); // R8
        AST_CORR_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq_corr[i]) |-> ($past(mem_rvalid && !mem_rerr) || $past(reg_wr))); // R2
        AST_CLEAR_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr && reg_tag == TAG_W'(i) && reg_sel == 2'd1 && reg_wdata[31] && !mem_rvalid)
            |=> (!irq_fault[i] && !irq_corr[i])); // R7
    end

endmodule

bind secded_rec_ram secded_rec_ram_chk #(.TAGS(TAGS), .TAG_W(TAG_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_rvalid (mem_rvalid),
    .mem_rerr   (mem_rerr),
    .reg_wr     (reg_wr),
    .reg_tag    (reg_tag),
    .reg_sel    (reg_sel),
    .reg_wdata  (reg_wdata),
    .irq_fault  (irq_fault),
    .irq_corr   (irq_corr)
);

// File: tb/secded_rec_ram_tb.sv
module secded_rec_ram_tb;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 4;
    localparam int TAGS   = 4;
    localparam int TAG_W  = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              mem_req = 1'b0, mem_we = 1'b0;
    logic [TAG_W-1:0]  mem_tag = '0;
    logic [ADDR_W-1:0] mem_addr = '0;
    logic [DATA_W-1:0] mem_wdata = '0;
    logic              mem_rvalid, mem_rerr;
    logic [DATA_W-1:0] mem_rdata;
    logic              reg_wr = 1'b0;
    logic [TAG_W-1:0]  reg_tag = '0;
    logic [1:0]        reg_sel = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic [TAGS-1:0]   irq_fault, irq_corr;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    secded_rec_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .TAGS(TAGS)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .mem_req(mem_req), .mem_we(mem_we), .mem_tag(mem_tag),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .mem_rerr(mem_rerr),
        .reg_wr(reg_wr), .reg_tag(reg_tag), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_fault(irq_fault), .irq_corr(irq_corr)
    );

    // {address, data}
    localparam logic [35:0] VEC [8] = '{
        {4'h0, 32'h0000_0000}, {4'hF, 32'hFFFF_FFFF},
        {4'h1, 32'hA5A5_5A5A}, {4'h2, 32'h0000_0001},
        {4'h3, 32'h8000_0000}, {4'h7, 32'h1234_5678},
        {4'h8, 32'hDEAD_BEEF}, {4'hE, 32'h0F0F_F0F0}
    };

    task automatic chk(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic do_write(input int tag, input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        mem_req = 1'b1; mem_we = 1'b1; mem_tag = TAG_W'(tag);
        mem_addr = a; mem_wdata = d;
        @(negedge clk);
        mem_req = 1'b0; mem_we = 1'b0;
        chk("R11", "rvalid after write", 32'(mem_rvalid), 32'd0);
    endtask

    task automatic do_read(input int tag, input logic [3:0] a,
                           output logic [31:0] d, output logic e, output logic v);
        @(negedge clk);
        mem_req = 1'b1; mem_we = 1'b0; mem_tag = TAG_W'(tag); mem_addr = a;
        @(negedge clk);
        d = mem_rdata; e = mem_rerr; v = mem_rvalid;
        mem_req = 1'b0;
        @(negedge clk);
    endtask

    task automatic reg_write(input int tag, input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_tag = TAG_W'(tag); reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input int tag, input logic [1:0] sel, output logic [31:0] d);
        reg_tag = TAG_W'(tag); reg_sel = sel;
        #1;
        d = reg_rdata;
    endtask

    initial begin
        logic [31:0] rd, r;
        logic        er, vl;

        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10", "rvalid", 32'(mem_rvalid), 32'd0);
        chk("R10", "irq_fault", 32'(irq_fault), 32'd0);
        chk("R10", "irq_corr", 32'(irq_corr), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int t = 0; t < TAGS; t++) begin
            for (int s = 0; s < 3; s++) begin
                reg_read(t, 2'(s), r);
                chk("R10", "reg after reset", r, 32'd0);
            end
        end

        // R1 vector table walk
        for (int i = 0; i < 8; i++) do_write(i % TAGS, VEC[i][35:32], VEC[i][31:0]);
        for (int i = 0; i < 8; i++) begin
            do_read(i % TAGS, VEC[i][35:32], rd, er, vl);
            chk("R1", "rdata", rd, VEC[i][31:0]);
            chk("R1", "rerr", 32'(er), 32'd0);
            chk("R1", "rvalid", 32'(vl), 32'd1);
        end

        // R9 detection off: correction and rerr, no record, no irq
        reg_write(0, 2'd0, 32'h16);
        do_read(0, 4'h1, rd, er, vl);
        chk("R9", "corrected data", rd, 32'hA5A5_5A5A);
        chk("R9", "rerr on CE", 32'(er), 32'd0);
        reg_read(0, 2'd1, r);
        chk("R9", "status not logged", r, 32'd0);
        chk("R9", "irq_corr", 32'(irq_corr), 32'd0);
        reg_read(0, 2'd0, r);
        chk("R4", "inject self clear", r, 32'h06);
        reg_write(0, 2'd0, 32'h26);
        do_read(0, 4'h2, rd, er, vl);
        chk("R9", "rerr on UE", 32'(er), 32'd1);
        reg_read(0, 2'd1, r);
        chk("R9", "status after UE", r, 32'd0);
        chk("R9", "irq_fault", 32'(irq_fault), 32'd0);

        // R2 corrected error on tag 1
        reg_write(1, 2'd0, 32'h15);
        reg_read(1, 2'd1, r);
        chk("R4", "armed only", r, 32'd0);
        chk("R4", "irq before read", 32'(irq_corr), 32'd0);
        do_read(1, 4'h7, rd, er, vl);
        chk("R2", "corrected data", rd, 32'h1234_5678);
        chk("R2", "rerr", 32'(er), 32'd0);
        reg_read(1, 2'd1, r);
        chk("R2", "status", r, 32'h8600_0000);
        reg_read(1, 2'd2, r);
        chk("R2", "address", r, 32'h7);
        chk("R8", "irq_corr", 32'(irq_corr), 32'b0010);
        chk("R8", "irq_fault", 32'(irq_fault), 32'd0);
        reg_read(1, 2'd0, r);
        chk("R4", "ctrl after read", r, 32'h05);
        for (int t = 0; t < TAGS; t++) begin
            if (t != 1) begin
                reg_read(t, 2'd1, r);
                chk("R5", "other set empty", r, 32'd0);
            end
        end
        do_read(1, 4'h8, rd, er, vl);
        chk("R4", "next read clean", rd, 32'hDEAD_BEEF);
        reg_read(1, 2'd1, r);
        chk("R4", "record unchanged", r, 32'h8600_0000);

        // R8 enable gating
        reg_write(1, 2'd0, 32'h01);
        chk("R8", "irq_corr disabled", 32'(irq_corr), 32'd0);
        reg_write(1, 2'd0, 32'h05);
        chk("R8", "irq_corr re-enabled", 32'(irq_corr), 32'b0010);

        // R7 clear
        reg_write(1, 2'd1, 32'hFFC0_0000);
        reg_read(1, 2'd1, r);
        chk("R7", "status cleared", r, 32'd0);
        reg_read(1, 2'd2, r);
        chk("R7", "address cleared", r, 32'd0);
        chk("R7", "irq_corr dropped", 32'(irq_corr), 32'd0);

        // R3 uncorrectable on tag 2, last address
        reg_write(2, 2'd0, 32'h23);
        do_read(2, 4'hF, rd, er, vl);
        chk("R3", "rerr", 32'(er), 32'd1);
        chk("R3", "rvalid", 32'(vl), 32'd1);
        reg_read(2, 2'd1, r);
        chk("R3", "status", r, 32'hA400_0000);
        reg_read(2, 2'd2, r);
        chk("R3", "address", r, 32'hF);
        chk("R8", "irq_fault", 32'(irq_fault), 32'b0100);
        chk("R8", "irq_corr", 32'(irq_corr), 32'd0);

        // R6 overflow keeps first record
        reg_write(2, 2'd0, 32'h17);
        do_read(2, 4'h3, rd, er, vl);
        chk("R6", "data corrected", rd, 32'h8000_0000);
        reg_read(2, 2'd1, r);
        chk("R6", "status with overflow", r, 32'hAC00_0000);
        reg_read(2, 2'd2, r);
        chk("R6", "first address kept", r, 32'hF);
        chk("R6", "irq_corr stays low", 32'(irq_corr), 32'd0);
        reg_write(2, 2'd1, 32'hFFC0_0000);
        chk("R7", "irq_fault dropped", 32'(irq_fault), 32'd0);
        reg_read(2, 2'd1, r);
        chk("R7", "status cleared", r, 32'd0);

        // R5 injection bound to its tag
        reg_write(3, 2'd0, 32'h11);
        do_read(0, 4'h0, rd, er, vl);
        chk("R5", "other tag clean", rd, 32'h0);
        reg_read(3, 2'd0, r);
        chk("R5", "arm kept", r, 32'h11);
        do_read(3, 4'hE, rd, er, vl);
        chk("R5", "own tag data", rd, 32'h0F0F_F0F0);
        reg_read(3, 2'd1, r);
        chk("R5", "own set logged", r, 32'h8600_0000);
        for (int t = 0; t < 3; t++) begin
            reg_read(t, 2'd1, r);
            chk("R5", "others empty", r, 32'd0);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule